// File: doc/BRIEF.md
# Burst-Only I2C Configuration Target

This block is an I2C target that holds the 24-bit divider and mode setting of a frequency synthesizer. It oversamples SCL and SDA on a system clock and detects START and STOP. It answers to a 7-bit address whose upper five bits are fixed and whose two lowest bits come from strap inputs. It sends and receives bytes, and it pulls SDA low through an output enable for ACK and for read data.

The host cannot choose a register. Every transaction begins at byte 0. A write carries bytes 0, 1 and 2 in that order into a shadow copy. The active setting, which drives the configuration outputs, is replaced only when all three bytes have arrived and a STOP follows. A shorter burst leaves the active setting as it was. A read returns the active bytes in order and then 0xFF. Reset loads the default setting.

Top module: `cfg_i2c_target`

## Requirements
- R1: The block acknowledges an address byte only when its upper seven bits equal {1,0,1,1,0, strap_adr[1], strap_adr[0]}. For any other address it gives no ACK and ignores every later bit until the next START.
- R2: Bit 0 of the address byte selects the direction: 0 means the host writes and 1 means the host reads.
- R3: Write data maps into the setting as follows. Byte 0 = M[9:2]. Byte 1 = {M[1:0], NA[2:0], NB[2:0]}. Byte 2 bit 1 = P and byte 2 bit 0 = bypass. Byte 2 bits 7..2 are unused.
- R4: The configuration outputs change only on a STOP that follows three acknowledged data bytes. Before that STOP they hold their old values.
- R5: A write that meets STOP after zero, one or two data bytes leaves the configuration outputs unchanged.
- R6: A read returns the active bytes 0, 1 and 2 in that order, then 0xFF for every further byte until the host NACKs. Unused bits read as 0, so byte 2 reads {6'b0, P, bypass}.
- R7: Every START resets the byte pointer to 0, so each write or read burst begins at byte 0.
- R8: Reset (rst_n low) sets M=625, NA=0, NB=0, P=1 and bypass=0. These read back as bytes 0x9C, 0x40, 0x02.
- R9: SDA is only ever pulled low, through sda_oe. sda_oe changes only while SCL is low, and it is released after each ACK, after the 8th read bit, and on STOP.
- R10: In a write, data bytes after the third get no ACK and do not change the setting. The first three bytes still commit on STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low master reset; loads the default setting |
| scl_i | input | 1 | Bus clock line as received |
| sda_i | input | 1 | Bus data line as received |
| sda_oe | output | 1 | When high, the pad pulls SDA low |
| strap_adr | input | 2 | Two lowest address bits, taken from strap pins |
| cfg_m | output | 10 | Active feedback divider M |
| cfg_na | output | 3 | Active output divider for channel A |
| cfg_nb | output | 3 | Active output divider for channel B |
| cfg_p | output | 1 | Active reference prescaler select |
| cfg_bypass | output | 1 | Active PLL bypass select |

## Verification
The bench aims at the commit boundary. It samples the outputs after the third data byte but before STOP; a design that commits byte by byte would already show the new divider there. It also sends bursts cut short at zero, one or two bytes; a design that merges a partial shadow would corrupt M or NA/NB. Further cases are wrong addresses, including the strap bits, which a loose comparator would acknowledge, a fourth write byte, which a pointer without saturation would wrap into byte 0, and reads past byte 2, which must give 0xFF and not repeat or index out of range. Written 1s in the unused bits of byte 2 must read back as 0.

// File: rtl/cfg_i2c_pkg.sv
package cfg_i2c_pkg;

  localparam int CFG_BYTES = 3;

  typedef struct packed {
    logic [9:0] m;
    logic [2:0] na;
    logic [2:0] nb;
    logic       p;
    logic       byp;
  } cfg_t;

  localparam cfg_t CFG_DEFAULT = '{m: 10'd625, na: 3'd0, nb: 3'd0, p: 1'b1, byp: 1'b0};

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_WR, ST_WR_ACK, ST_RD, ST_RD_ACK, ST_SKIP
  } bus_st_t;

  // byte view of the setting; indices past the file read as all ones
  function automatic logic [7:0] cfg_byte(input cfg_t c, input int idx);
    logic [7:0] b;
    case (idx)
      0:       b = c.m[9:2];
      1:       b = {c.m[1:0], c.na, c.nb};
      2:       b = {6'b0, c.p, c.byp};
      default: b = 8'hFF;
    endcase
    return b;
  endfunction

  // place one received byte into a setting, dropping unused bits
  function automatic cfg_t cfg_merge(input cfg_t c, input int idx, input logic [7:0] b);
    cfg_t r;
    r = c;
    case (idx)
      0: r.m[9:2] = b;
      1: begin
        r.m[1:0] = b[7:6];
        r.na     = b[5:3];
        r.nb     = b[2:0];
      end
      2: begin
        r.p   = b[1];
        r.byp = b[0];
      end
      default: r = c;
    endcase
    return r;
  endfunction

  function automatic logic addr_hit(input logic [7:0] rx, input logic [4:0] hi,
                                    input logic [1:0] strap);
    return rx[7:1] == {hi, strap};
  endfunction

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic ev_start,
  output logic ev_stop
);
  logic [STAGES-1:0] scl_q, sda_q;
  logic              scl_d, sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= '1;
      sda_q <= '1;
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_q <= {scl_q[STAGES-2:0], scl_i};
      sda_q <= {sda_q[STAGES-2:0], sda_i};
      scl_d <= scl_q[STAGES-1];
      sda_d <= sda_q[STAGES-1];
    end
  end

  assign scl_s    = scl_q[STAGES-1];
  assign sda_s    = sda_q[STAGES-1];
  assign scl_rise = scl_s & ~scl_d;
  assign scl_fall = ~scl_s & scl_d;
  assign ev_start = scl_s & scl_d & sda_d & ~sda_s;
  assign ev_stop  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/i2c_burst_engine.sv
module i2c_burst_engine
  import cfg_i2c_pkg::*;
#(
  parameter logic [4:0] ADDR_HI = 5'b10110,
  parameter int         NBYTES  = CFG_BYTES,
  localparam int        PW      = $clog2(NBYTES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sda_s,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          ev_start,
  input  logic          ev_stop,
  input  logic [1:0]    strap_adr,
  input  logic [7:0]    rd_byte,
  output logic [PW-1:0] rd_idx,
  output logic [PW-1:0] ptr,
  output logic          wr_en,
  output logic [7:0]    wr_data,
  output logic          commit,
  output logic          sda_oe
);
  bus_st_t     st;
  logic [3:0]  bitcnt;
  logic [7:0]  shreg, tx;
  logic        rw, host_nack;
  logic        byte_done, hit;
  logic [PW-1:0] ptr_nxt;

  assign byte_done = scl_fall && (bitcnt == 4'd8);
  assign hit       = addr_hit(shreg, ADDR_HI, strap_adr);
  assign ptr_nxt   = (int'(ptr) == NBYTES) ? ptr : ptr + 1'b1;
  assign rd_idx    = (st == ST_RD_ACK) ? ptr_nxt : ptr;
  assign wr_en     = (st == ST_WR) && byte_done && (int'(ptr) < NBYTES);
  assign wr_data   = shreg;
  assign commit    = ev_stop && !rw && (int'(ptr) == NBYTES);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      bitcnt    <= '0;
      shreg     <= '0;
      tx        <= '0;
      rw        <= 1'b0;
      host_nack <= 1'b1;
      ptr       <= '0;
      sda_oe    <= 1'b0;
    end else if (ev_start) begin
      st     <= ST_ADDR;
      bitcnt <= '0;
      ptr    <= '0;
      rw     <= 1'b0;
      sda_oe <= 1'b0;
    end else if (ev_stop) begin
      st     <= ST_IDLE;
      sda_oe <= 1'b0;
    end else begin
      unique case (st)
        ST_ADDR, ST_WR: begin
          if (scl_rise && bitcnt < 4'd8) begin
            shreg  <= {shreg[6:0], sda_s};
            bitcnt <= bitcnt + 4'd1;
          end else if (byte_done) begin
            if (st == ST_ADDR) begin
              if (hit) begin
                rw     <= shreg[0];
                sda_oe <= 1'b1;
                st     <= ST_ADDR_ACK;
              end else begin
                st <= ST_SKIP;
              end
            end else if (int'(ptr) < NBYTES) begin
              ptr    <= ptr + 1'b1;
              sda_oe <= 1'b1;
              st     <= ST_WR_ACK;
            end else begin
              st <= ST_SKIP;
            end
          end
        end
        ST_ADDR_ACK: if (scl_fall) begin
          bitcnt <= '0;
          if (rw) begin
            tx     <= rd_byte;
            sda_oe <= ~rd_byte[7];
            st     <= ST_RD;
          end else begin
            sda_oe <= 1'b0;
            st     <= ST_WR;
          end
        end
        ST_WR_ACK: if (scl_fall) begin
          sda_oe <= 1'b0;
          bitcnt <= '0;
          st     <= ST_WR;
        end
        ST_RD: if (scl_fall) begin
          if (bitcnt == 4'd7) begin
            sda_oe <= 1'b0;
            bitcnt <= '0;
            st     <= ST_RD_ACK;
          end else begin
            tx     <= {tx[6:0], 1'b0};
            sda_oe <= ~tx[6];
            bitcnt <= bitcnt + 4'd1;
          end
        end
        ST_RD_ACK: begin
          if (scl_rise) host_nack <= sda_s;
          else if (scl_fall) begin
            if (host_nack) st <= ST_SKIP;
            else begin
              ptr    <= ptr_nxt;
              tx     <= rd_byte;
              sda_oe <= ~rd_byte[7];
              st     <= ST_RD;
            end
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/cfg_shadow_file.sv
module cfg_shadow_file
  import cfg_i2c_pkg::*;
#(
  parameter int  NBYTES = CFG_BYTES,
  localparam int PW     = $clog2(NBYTES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [PW-1:0] wr_idx,
  input  logic [7:0]    wr_data,
  input  logic          commit,
  input  logic [PW-1:0] rd_idx,
  output logic [7:0]    rd_data,
  output cfg_t          active
);
  cfg_t shadow;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow <= CFG_DEFAULT;
      active <= CFG_DEFAULT;
    end else begin
      if (wr_en)  shadow <= cfg_merge(shadow, int'(wr_idx), wr_data);
      if (commit) active <= shadow;
    end
  end

  assign rd_data = (int'(rd_idx) < NBYTES) ? cfg_byte(active, int'(rd_idx)) : 8'hFF;
endmodule

// File: rtl/cfg_i2c_target.sv
module cfg_i2c_target
  import cfg_i2c_pkg::*;
#(
  parameter logic [4:0] ADDR_HI     = 5'b10110,
  parameter int         SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  input  logic [1:0] strap_adr,
  output logic [9:0] cfg_m,
  output logic [2:0] cfg_na,
  output logic [2:0] cfg_nb,
  output logic       cfg_p,
  output logic       cfg_bypass
);
  localparam int PW = $clog2(CFG_BYTES + 1);

  logic          scl_s, sda_s, scl_rise, scl_fall, ev_start, ev_stop;
  logic          wr_en, commit;
  logic [7:0]    wr_data, rd_byte;
  logic [PW-1:0] rd_idx, ptr;
  cfg_t          active;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .ev_start(ev_start), .ev_stop(ev_stop)
  );

  i2c_burst_engine #(.ADDR_HI(ADDR_HI), .NBYTES(CFG_BYTES)) u_eng (
    .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .ev_start(ev_start), .ev_stop(ev_stop),
    .strap_adr(strap_adr), .rd_byte(rd_byte), .rd_idx(rd_idx), .ptr(ptr),
    .wr_en(wr_en), .wr_data(wr_data), .commit(commit), .sda_oe(sda_oe)
  );

  cfg_shadow_file #(.NBYTES(CFG_BYTES)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(ptr), .wr_data(wr_data),
    .commit(commit), .rd_idx(rd_idx), .rd_data(rd_byte), .active(active)
  );

  assign cfg_m      = active.m;
  assign cfg_na     = active.na;
  assign cfg_nb     = active.nb;
  assign cfg_p      = active.p;
  assign cfg_bypass = active.byp;
endmodule

// File: rtl/cfg_i2c_target_chk.sv
module cfg_i2c_target_chk #(
  parameter int PW = 2,
  parameter int NBYTES = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          scl_s,
  input logic          ev_start,
  input logic          ev_stop,
  input logic          commit,
  input logic [PW-1:0] ptr,
  input logic          sda_oe,
  input logic [17:0]   cfg_all
);
  AST_COMMIT_NEEDS_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> ev_stop); // R4
  AST_CFG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(cfg_all)); // R5
  AST_PTR_ZERO_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
    ev_start |=> (ptr == '0)); // R7
  AST_PTR_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    int'(ptr) <= NBYTES); // R10
  AST_SDA_PULL_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_s); // R9
  AST_SDA_FREE_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    ev_stop |=> !sda_oe); // R9
endmodule

bind cfg_i2c_target cfg_i2c_target_chk #(.PW(PW), .NBYTES(cfg_i2c_pkg::CFG_BYTES)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .ev_start(ev_start), .ev_stop(ev_stop),
  .commit(commit), .ptr(ptr), .sda_oe(sda_oe),
  .cfg_all({cfg_m, cfg_na, cfg_nb, cfg_p, cfg_bypass})
);

// File: tb/cfg_i2c_target_tb.sv
`timescale 1ns/1ps
module cfg_i2c_target_tb;
  localparam int HP = 10;

  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, sda_h = 1'b1;
  logic [1:0] strap = 2'b00;
  logic sda_oe, cfg_p, cfg_bypass;
  logic [9:0] cfg_m;
  logic [2:0] cfg_na, cfg_nb;
  wire sda_line = sda_h & ~sda_oe;

  int n_chk = 0, n_fail = 0, viol = 0;
  logic [7:0] exp_b [0:2];
  logic [7:0] wbuf [0:3];
  logic [7:0] rbuf [0:4];
  bit done = 0;

  always #2.5 clk = ~clk;

  cfg_i2c_target u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_oe(sda_oe),
    .strap_adr(strap), .cfg_m(cfg_m), .cfg_na(cfg_na), .cfg_nb(cfg_nb),
    .cfg_p(cfg_p), .cfg_bypass(cfg_bypass)
  );

  logic prev_oe = 1'b0;
  always @(posedge clk) begin
    if (rst_n && scl && sda_oe != prev_oe) viol++;  // R9 monitor
    prev_oe <= sda_oe;
  end

  task automatic check(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, expv);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  // expected outputs rebuilt from the R3 byte layout
  function automatic logic [17:0] exp_outputs();
    return {exp_b[0], exp_b[1][7:6], exp_b[1][5:3], exp_b[1][2:0], exp_b[2][1], exp_b[2][0]};
  endfunction

  function automatic logic [6:0] my_addr();
    return {5'b10110, strap};
  endfunction

  task automatic check_cfg(input string req);
    logic [17:0] act;
    act = {cfg_m, cfg_na, cfg_nb, cfg_p, cfg_bypass};
    check(act == exp_outputs(), req, int'(act), int'(exp_outputs()));
  endtask

  task automatic i2c_start();
    sda_h = 1'b1; scl = 1'b1; wt(HP);
    sda_h = 1'b0; wt(HP);
    scl = 1'b0; wt(2);
  endtask

  task automatic i2c_stop();
    sda_h = 1'b0; wt(HP);
    scl = 1'b1; wt(HP);
    sda_h = 1'b1; wt(HP);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      sda_h = b[i]; wt(HP);
      scl = 1'b1; wt(HP);
      scl = 1'b0; wt(2);
    end
    sda_h = 1'b1; wt(HP);
    scl = 1'b1; wt(HP / 2);
    ack = (sda_line == 1'b0);
    wt(HP / 2);
    scl = 1'b0; wt(2);
  endtask

  task automatic read_byte(input bit nack, output logic [7:0] b);
    sda_h = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wt(HP);
      scl = 1'b1; wt(HP / 2);
      b[i] = sda_line;
      wt(HP / 2);
      scl = 1'b0; wt(2);
    end
    sda_h = nack; wt(HP);
    scl = 1'b1; wt(HP);
    scl = 1'b0; wt(2);
    sda_h = 1'b1;
  endtask

  task automatic do_write(input logic [6:0] a7, input int n, input bit stop_it,
                          output bit aack, output int dacks);
    bit k;
    i2c_start();
    send_byte({a7, 1'b0}, aack);
    dacks = 0;
    for (int i = 0; i < n; i++) begin
      send_byte(wbuf[i], k);
      if (k) dacks++;
    end
    if (stop_it) i2c_stop();
  endtask

  task automatic do_read(input logic [6:0] a7, input int n, output bit aack);
    i2c_start();
    send_byte({a7, 1'b1}, aack);
    for (int i = 0; i < n; i++) read_byte(i == n - 1, rbuf[i]);
    i2c_stop();
  endtask

  task automatic commit_model();
    exp_b[0] = wbuf[0];
    exp_b[1] = wbuf[1];
    exp_b[2] = wbuf[2] & 8'h03;
  endtask

  task automatic reset_model();
    exp_b[0] = 8'h9C; exp_b[1] = 8'h40; exp_b[2] = 8'h02;
  endtask

  task automatic readback(input string req);
    bit a;
    do_read(my_addr(), 3, a);
    check(a, req, int'(a), 1);
    for (int i = 0; i < 3; i++) check(rbuf[i] == exp_b[i], req, int'(rbuf[i]), int'(exp_b[i]));
  endtask

  initial begin
    bit a;
    int d;
    void'($urandom(32'd20240611));
    reset_model();
    wt(10);
    rst_n = 1'b1;
    wt(10);

    // R8 reset state, R6/R2 read of defaults
    check_cfg("R8 reset outputs");
    check(sda_oe == 1'b0, "R9 idle release", int'(sda_oe), 0);
    readback("R6 R2 R8 default readback");

    // R3/R4: outputs hold until STOP
    wbuf[0] = 8'hA5; wbuf[1] = 8'h5B; wbuf[2] = 8'h01;
    do_write(my_addr(), 3, 1'b0, a, d);
    check(a, "R1 R2 write address ack", int'(a), 1);
    check(d == 3, "R3 data acks", d, 3);
    wt(HP);
    check_cfg("R4 held before STOP");
    i2c_stop();
    commit_model();
    check_cfg("R3 R4 committed on STOP");

    // R6: unused bits read as zero
    wbuf[0] = 8'h12; wbuf[1] = 8'hC7; wbuf[2] = 8'hFF;
    do_write(my_addr(), 3, 1'b1, a, d);
    commit_model();
    readback("R6 unused bits zero");

    // R7: a new burst restarts at byte 0
    wbuf[0] = 8'h3C; wbuf[1] = 8'h81; wbuf[2] = 8'h02;
    do_write(my_addr(), 3, 1'b1, a, d);
    commit_model();
    check_cfg("R7 second burst starts at byte 0");

    // R10: fourth byte NACKed and ignored
    wbuf[0] = 8'hE1; wbuf[1] = 8'h2A; wbuf[2] = 8'h03; wbuf[3] = 8'h77;
    do_write(my_addr(), 4, 1'b1, a, d);
    commit_model();
    check(d == 3, "R10 extra byte nack", d, 3);
    check_cfg("R10 first three committed");

    // R6: reading past the file returns 0xFF
    do_read(my_addr(), 5, a);
    for (int i = 0; i < 3; i++) check(rbuf[i] == exp_b[i], "R6 read order", int'(rbuf[i]), int'(exp_b[i]));
    check(rbuf[3] == 8'hFF && rbuf[4] == 8'hFF, "R6 past end 0xFF", int'({rbuf[3], rbuf[4]}), 16'hFFFF);

    // R1: strap-bit mismatch
    strap = 2'b10;
    wbuf[0] = 8'h00; wbuf[1] = 8'h00; wbuf[2] = 8'h00;
    do_write({5'b10110, 2'b01}, 3, 1'b1, a, d);
    check(!a, "R1 strap mismatch nack", int'(a), 0);
    check(d == 0, "R1 ignored data", d, 0);
    check_cfg("R1 outputs unchanged");

    // random mix
    for (int t = 0; t < 24; t++) begin
      int kind;
      strap = 2'($urandom_range(0, 3));
      for (int i = 0; i < 4; i++) wbuf[i] = 8'($urandom);
      kind = $urandom_range(0, 3);
      if (kind <= 1) begin
        do_write(my_addr(), 3, 1'b1, a, d);
        commit_model();
        check_cfg("R3 R4 random commit");
        if (kind == 1) readback("R6 random readback");
      end else if (kind == 2) begin
        do_write(my_addr(), $urandom_range(0, 2), 1'b1, a, d);
        check_cfg("R5 short burst discarded");
      end else begin
        logic [6:0] bad;
        bad = 7'($urandom);
        if (bad == my_addr()) bad = bad ^ 7'h01;
        do_write(bad, 3, 1'b1, a, d);
        check(!a, "R1 wrong address nack", int'(a), 0);
        check_cfg("R1 wrong address ignored");
      end
    end

    // R8: reset in mid-run restores defaults
    rst_n = 1'b0; wt(4); rst_n = 1'b1; wt(4);
    reset_model();
    check_cfg("R8 reset after writes");
    readback("R8 readback after reset");

    check(viol == 0, "R9 sda_oe moved while SCL high", viol, 0);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule